// File: doc/BRIEF.md
# Relocation and Limit Protection Unit

This block sits between a processor's address generation and memory. It keeps two values for the running process: a relocation value and a limit. A user-mode request has its logical address compared with the limit. If the address is inside the range, the relocation value is added to it and the access is granted. If the address is outside the range, or the addition does not fit in the physical width, the block raises a protection fault and no address is passed on. A kernel-mode request is passed through untranslated and unchecked, so the kernel can reach every physical location.

The two values are loaded through a small configuration port. Only a requester in kernel mode may load them. A load attempted from user mode changes nothing and raises a privilege-violation flag for one cycle. A new relocation value, for example after the operating system compacts memory, takes effect on the very next request. No other state has to be flushed. Every response is registered and appears exactly one cycle after its request.

Top module: `relocProtUnit`

## Requirements
- R1: Each request (reqValid high in a cycle) produces a response with rspValid high exactly one cycle later. In a cycle after which no request was taken, rspValid, rspGrant, rspFault and rspWrite are all low.
- R2: A user-mode request (reqKernel low) whose zero-extended logical address is strictly below the limit, and whose sum with the relocation value fits in PHYS_W bits, responds with rspGrant high, rspFault low and rspAddr equal to relocation plus address.
- R3: A user-mode request whose address is equal to or above the limit responds with rspFault high, rspGrant low and rspAddr zero.
- R4: A user-mode request whose relocation-plus-address sum carries out of PHYS_W bits responds with rspFault high, rspGrant low and rspAddr zero, even when the address is below the limit.
- R5: A kernel-mode request (reqKernel high) always responds with rspGrant high, rspFault low and rspAddr equal to the zero-extended logical address, whatever the relocation and limit values are.
- R6: A configuration write (cfgValid high) with cfgKernel high loads cfgData into the relocation value when cfgSel is 0, and into the limit when cfgSel is 1. A request in the cycle after the write uses the new value. A request in the same cycle as the write uses the old value.
- R7: A configuration write with cfgKernel low leaves both values unchanged. It raises privFault for exactly one cycle, in the cycle after the write. privFault is otherwise low.
- R8: After reset the relocation value and the limit are both zero and all outputs are low. A user-mode request made right after reset therefore faults.
- R9: rspWrite in a response equals the reqWrite of its request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqAddr | input | LOG_W | Logical address |
| reqWrite | input | 1 | 1 for a write access, 0 for a read |
| reqKernel | input | 1 | 1 when the requester is in kernel mode |
| cfgValid | input | 1 | Configuration write present this cycle |
| cfgSel | input | 1 | 0 selects relocation, 1 selects limit |
| cfgData | input | PHYS_W | Value to load |
| cfgKernel | input | 1 | 1 when the configuration writer is in kernel mode |
| rspValid | output | 1 | Response present |
| rspAddr | output | PHYS_W | Physical address, zero on a fault |
| rspGrant | output | 1 | Access allowed |
| rspFault | output | 1 | Protection fault |
| rspWrite | output | 1 | Read/write flag of the answered request |
| privFault | output | 1 | Rejected user-mode configuration write |

## Verification
A wrong relocation or limit register shows up on the next user-mode request. The physical address is then off by the error, or a grant and a fault trade places one cycle after the request. The bench therefore follows every configuration write, including rejected ones, with requests on both sides of the limit. A broken bound compare or carry detection shows up in the same single cycle, through the edge addresses: limit minus one, the limit itself, and a sum just past the top of the physical range.

// File: rtl/relocPkg.sv
package relocPkg;
  typedef struct packed {
    logic relocWe;
    logic limitWe;
    logic userReq;
    logic kernelReq;
  } ctrlStrobe_t;
endpackage

// File: rtl/relocCtrl.sv
module relocCtrl
  import relocPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqKernel,
  input  logic        cfgValid,
  input  logic        cfgSel,
  input  logic        cfgKernel,
  output ctrlStrobe_t strobe,
  output logic        privFault
);
  logic cfgAllowed;

  assign cfgAllowed = cfgValid && cfgKernel;

  always_comb begin
    strobe.relocWe   = cfgAllowed && !cfgSel;
    strobe.limitWe   = cfgAllowed && cfgSel;
    strobe.userReq   = reqValid && !reqKernel;
    strobe.kernelReq = reqValid && reqKernel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) privFault <= 1'b0;
    else       privFault <= cfgValid && !cfgKernel;
  end

  // R7
  priv_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgValid && !cfgKernel) |=> privFault);

  // R7
  priv_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgValid && !cfgKernel) |=> !privFault);

  // R6
  single_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.relocWe, strobe.limitWe}));
endmodule

// File: rtl/relocDatapath.sv
module relocDatapath
  import relocPkg::*;
#(
  parameter int LOG_W  = 16,
  parameter int PHYS_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [LOG_W-1:0]  reqAddr,
  input  logic              reqWrite,
  input  logic [PHYS_W-1:0] cfgData,
  output logic              rspValid,
  output logic [PHYS_W-1:0] rspAddr,
  output logic              rspGrant,
  output logic              rspFault,
  output logic              rspWrite
);
  localparam int SUM_W = PHYS_W + 1;

  logic [PHYS_W-1:0] relocReg;
  logic [PHYS_W-1:0] limitReg;
  logic [PHYS_W-1:0] extAddr;
  logic [SUM_W-1:0]  sumFull;
  logic              inBounds;
  logic              carryOut;
  logic              userOk;

  always_comb begin
    extAddr  = PHYS_W'(reqAddr);
    sumFull  = {1'b0, relocReg} + {1'b0, extAddr};
    carryOut = sumFull[PHYS_W];
    inBounds = extAddr < limitReg;
    userOk   = strobe.userReq && inBounds && !carryOut;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      relocReg <= '0;
      limitReg <= '0;
    end else begin
      if (strobe.relocWe) relocReg <= cfgData;
      if (strobe.limitWe) limitReg <= cfgData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspGrant <= 1'b0;
      rspFault <= 1'b0;
      rspWrite <= 1'b0;
      rspAddr  <= '0;
    end else begin
      rspValid <= strobe.userReq || strobe.kernelReq;
      rspGrant <= strobe.kernelReq || userOk;
      rspFault <= strobe.userReq && !userOk;
      rspWrite <= (strobe.userReq || strobe.kernelReq) && reqWrite;
      if (strobe.kernelReq)  rspAddr <= extAddr;
      else if (userOk)       rspAddr <= sumFull[PHYS_W-1:0];
      else                   rspAddr <= '0;
    end
  end

  // R2
  grant_fault_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rspGrant && rspFault));

  // R3
  fault_addr_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspFault |-> (rspAddr == '0));

  // R3
  out_of_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.userReq && !(extAddr < limitReg)) |=> (rspFault && !rspGrant));

  // R5
  kernel_bypass_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.kernelReq |=> (rspGrant && rspAddr == $past(extAddr)));

  // R1
  resp_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.userReq || strobe.kernelReq) |=> (rspValid && (rspGrant || rspFault)));

  // R7
  regs_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.relocWe || strobe.limitWe) |=> ($stable(relocReg) && $stable(limitReg)));
endmodule

// File: rtl/relocProtUnit.sv
module relocProtUnit
  import relocPkg::*;
#(
  parameter int LOG_W  = 16,
  parameter int PHYS_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [LOG_W-1:0]  reqAddr,
  input  logic              reqWrite,
  input  logic              reqKernel,
  input  logic              cfgValid,
  input  logic              cfgSel,
  input  logic [PHYS_W-1:0] cfgData,
  input  logic              cfgKernel,
  output logic              rspValid,
  output logic [PHYS_W-1:0] rspAddr,
  output logic              rspGrant,
  output logic              rspFault,
  output logic              rspWrite,
  output logic              privFault
);
  ctrlStrobe_t strobe;

  relocCtrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqKernel (reqKernel),
    .cfgValid  (cfgValid),
    .cfgSel    (cfgSel),
    .cfgKernel (cfgKernel),
    .strobe    (strobe),
    .privFault (privFault)
  );

  relocDatapath #(.LOG_W(LOG_W), .PHYS_W(PHYS_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqAddr  (reqAddr),
    .reqWrite (reqWrite),
    .cfgData  (cfgData),
    .rspValid (rspValid),
    .rspAddr  (rspAddr),
    .rspGrant (rspGrant),
    .rspFault (rspFault),
    .rspWrite (rspWrite)
  );
endmodule

// File: tb/test_relocProtUnit.sv
`timescale 1ns/1ps
module test_relocProtUnit;
  localparam int LOG_W  = 16;
  localparam int PHYS_W = 20;
  localparam int EXP_W  = PHYS_W + 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [LOG_W-1:0]  reqAddr = '0;
  logic              reqWrite = 1'b0;
  logic              reqKernel = 1'b0;
  logic              cfgValid = 1'b0;
  logic              cfgSel = 1'b0;
  logic [PHYS_W-1:0] cfgData = '0;
  logic              cfgKernel = 1'b0;
  logic              rspValid;
  logic [PHYS_W-1:0] rspAddr;
  logic              rspGrant;
  logic              rspFault;
  logic              rspWrite;
  logic              privFault;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  logic [EXP_W-1:0] expQ[$];
  string            tagQ[$];

  logic [PHYS_W-1:0] mReloc = '0;
  logic [PHYS_W-1:0] mLimit = '0;

  always #2.5 clk = ~clk;

  relocProtUnit #(.LOG_W(LOG_W), .PHYS_W(PHYS_W)) i_relocProtUnit (.*);

  function automatic logic [EXP_W-1:0] model(input logic [LOG_W-1:0] a,
                                             input logic w, input logic k);
    logic [PHYS_W:0] s;
    s = {1'b0, mReloc} + {1'b0, PHYS_W'(a)};
    if (k) return {1'b1, 1'b0, w, PHYS_W'(a)};
    if ((PHYS_W'(a) < mLimit) && !s[PHYS_W]) return {1'b1, 1'b0, w, s[PHYS_W-1:0]};
    return {1'b0, 1'b1, w, {PHYS_W{1'b0}}};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReq(input string tag, input logic [LOG_W-1:0] a,
                       input logic w, input logic k);
    reqValid = 1'b1; reqAddr = a; reqWrite = w; reqKernel = k;
    expQ.push_back(model(a, w, k));
    tagQ.push_back(tag);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic doCfg(input string tag, input logic sel,
                       input logic [PHYS_W-1:0] d, input logic k);
    cfgValid = 1'b1; cfgSel = sel; cfgData = d; cfgKernel = k;
    @(negedge clk);
    cfgValid = 1'b0;
    if (k) begin
      if (sel) mLimit = d; else mReloc = d;
    end
    check({tag, " privFault"}, 32'(privFault), 32'(!k));
    @(negedge clk);
    check({tag, " privFault one cycle"}, 32'(privFault), 32'd0);
  endtask

  // monitor: compares every response against the scoreboard
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (expQ.size() == 0) begin
        check("R1 unexpected response", 32'd1, 32'd0);
      end else begin
        logic [EXP_W-1:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check({t, " grant"}, 32'(rspGrant), 32'(e[EXP_W-1]));
        check({t, " fault"}, 32'(rspFault), 32'(e[EXP_W-2]));
        check({t, " R9 write"}, 32'(rspWrite), 32'(e[EXP_W-3]));
        check({t, " addr"}, 32'(rspAddr), 32'(e[PHYS_W-1:0]));
      end
    end else if (rstN) begin
      check("R1 idle outputs", {28'd0, rspValid, rspGrant, rspFault, rspWrite}, 32'd0);
    end
  end

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
          mismatched++;
          compared++;
          $display("FAIL watchdog expired actual=hung expected=done");
          $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
          $finish;
        end
      end
    join_none

    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 reset rspValid", 32'(rspValid), 32'd0);
    check("R8 reset privFault", 32'(privFault), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    doReq("R8 user after reset", 16'h0000, 1'b0, 1'b0);
    @(negedge clk);

    // R5 kernel bypass with zero limit
    doReq("R5 kernel bypass", 16'hBEEF, 1'b1, 1'b1);
    @(negedge clk);

    // R6 load relocation and limit
    doCfg("R6 reloc load", 1'b0, 20'h04000, 1'b1);
    doCfg("R6 limit load", 1'b1, 20'h01000, 1'b1);

    // R2 in range, several patterns, back to back
    doReq("R2 addr zero", 16'h0000, 1'b0, 1'b0);
    doReq("R2 mid write", 16'h0234, 1'b1, 1'b0);
    doReq("R2 limit-1", 16'h0FFF, 1'b0, 1'b0);
    // R3 boundaries
    doReq("R3 equal limit", 16'h1000, 1'b1, 1'b0);
    doReq("R3 above limit", 16'hFFFF, 1'b0, 1'b0);
    doReq("R5 kernel above limit", 16'hFFFF, 1'b0, 1'b1);
    @(negedge clk);
    @(negedge clk);

    // R7 user write rejected, registers unchanged
    doCfg("R7 user reloc write", 1'b0, 20'h00000, 1'b0);
    doCfg("R7 user limit write", 1'b1, 20'hFFFFF, 1'b0);
    doReq("R7 reloc kept", 16'h0010, 1'b0, 1'b0);
    doReq("R7 limit kept", 16'h1000, 1'b0, 1'b0);
    @(negedge clk);

    // R6 compaction: new relocation used by next request; same-cycle uses old
    cfgValid = 1'b1; cfgSel = 1'b0; cfgData = 20'h00100; cfgKernel = 1'b1;
    doReq("R6 same-cycle old reloc", 16'h0020, 1'b0, 1'b0);
    cfgValid = 1'b0;
    mReloc = 20'h00100;
    doReq("R6 next-cycle new reloc", 16'h0020, 1'b0, 1'b0);
    @(negedge clk);

    // R4 carry out of physical width
    doCfg("R4 reloc high", 1'b0, 20'hFFFF0, 1'b1);
    doCfg("R4 limit high", 1'b1, 20'hFFFFF, 1'b1);
    doReq("R4 overflow", 16'h0020, 1'b0, 1'b0);
    doReq("R4 exact top", 16'h000F, 1'b1, 1'b0);
    doReq("R4 one past top", 16'h0010, 1'b0, 1'b0);
    @(negedge clk);
    @(negedge clk);

    check("R1 scoreboard drained", 32'(expQ.size()), 32'd0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule